// File: doc/BRIEF.md
# Bridge Driver Fault Supervisor

This block decides when the power stages of a multi-bridge motor driver may conduct. It takes the sleep request, a thermal trip flag and its matching release flag, a gate-drive supply undervoltage flag, the power-on reset, and one short-circuit flag per bridge. From these it produces one enable shared by all bridges, a charge-pump enable, and an active-low open-drain fault pin. The pin is modelled as a single "pull low" output: 1 means the pad is driven low and 0 means it is released.

There are two kinds of fault. Thermal and undervoltage faults recover by themselves: they mask the outputs only while the condition is present. A short is different. Once the short flag on a bridge has been seen on two clock edges in a row, the block latches an overcurrent fault. That latch shuts every bridge off and holds the fault pin low until either sleep is entered or power is cycled. After sleep ends, and after any undervoltage, the enable stays off until the supply has been reported good for a settling count of cycles.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `drv_en` is 0, `fault_pull_low` is 0 and the settling count is zero.
- R2: `uv_flag` high forces `drv_en` to 0 in the same cycle. `drv_en` can return only after SETTLE_CYCLES consecutive clock edges at which `sleep_n`=1 and `uv_flag`=0.
- R3: `ot_trip` high at an edge sets the thermal fault, which masks `drv_en` from that edge on. The fault clears at an edge where `ot_clear`=1 and `ot_trip`=0. When both flags are high at the same edge, the trip wins.
- R4: A short flag that is high on the same bridge at two consecutive edges latches the overcurrent fault at the second edge. A flag that is high for a single edge latches nothing.
- R5: Once latched, the overcurrent fault stays set after the short flags fall, and it holds `drv_en` at 0.
- R6: An edge with `sleep_n`=0 clears the overcurrent latch and the short filters. Clearing takes priority over setting.
- R7: `pump_en` equals `sleep_n`, and `drv_en` is 0 while `sleep_n` is 0.
- R8: `fault_pull_low` is 1 exactly when the overcurrent latch is set. Thermal and undervoltage faults never drive it.
- R9: `drv_en` = `sleep_n` AND NOT `uv_flag` AND settled AND NOT thermal fault AND NOT overcurrent latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_n | input | 1 | Sleep request, active low |
| ot_trip | input | 1 | Over-temperature trip flag |
| ot_clear | input | 1 | Over-temperature release flag |
| uv_flag | input | 1 | Gate-drive supply undervoltage flag |
| short_det | input | N_BRIDGE | Short-circuit flag, one bit per bridge |
| drv_en | output | 1 | Shared enable for all bridges |
| pump_en | output | 1 | Charge-pump enable |
| fault_pull_low | output | 1 | 1 = drive the open-drain fault pin low |

## Verification
The hardest state to reach from the ports is a latched overcurrent fault that coincides with sleep entry, or with a short that lasts exactly one edge. Purely random flags seldom line these up. The stimulus therefore gives each bridge's short flag a chance to persist across edges, which produces one-edge glitches, two-edge latches and longer events. Directed sequences add a glitch followed by a gap, a latch released by sleep while the short is still present, and trip and release arriving at the same edge.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef struct packed {
    logic thermal;
    logic overcur;
    logic settled;
  } fsup_state_t;
endpackage

// File: rtl/fsup_thermal.sv
module fsup_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic release_i,
  output logic hot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hot <= 1'b0;
    else if (trip)      hot <= 1'b1;
    else if (release_i) hot <= 1'b0;
  end
endmodule

// File: rtl/fsup_short_latch.sv
module fsup_short_latch #(
  parameter int N_BRIDGE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wipe,
  input  logic [N_BRIDGE-1:0] short_det,
  output logic                latched
);
  logic [N_BRIDGE-1:0] seen_q;
  logic [N_BRIDGE-1:0] confirm;

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seen_q[b] <= 1'b0;
      else if (wipe) seen_q[b] <= 1'b0;
      else           seen_q[b] <= short_det[b];
    end
    assign confirm[b] = seen_q[b] & short_det[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latched <= 1'b0;
    else if (wipe)       latched <= 1'b0;
    else if (|confirm)   latched <= 1'b1;
  end
endmodule

// File: rtl/fsup_settle_timer.sv
module fsup_settle_timer #(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (hold)          cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end
  assign settled = (cnt_q == LIMIT);
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int N_BRIDGE      = 4,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_n,
  input  logic                ot_trip,
  input  logic                ot_clear,
  input  logic                uv_flag,
  input  logic [N_BRIDGE-1:0] short_det,
  output logic                drv_en,
  output logic                pump_en,
  output logic                fault_pull_low
);
  fsup_state_t st;

  fsup_thermal u_therm (
    .clk(clk), .rst_n(rst_n), .trip(ot_trip), .release_i(ot_clear), .hot(st.thermal)
  );

  fsup_short_latch #(.N_BRIDGE(N_BRIDGE)) u_short (
    .clk(clk), .rst_n(rst_n), .wipe(!sleep_n), .short_det(short_det), .latched(st.overcur)
  );

  fsup_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .hold(!sleep_n || uv_flag), .settled(st.settled)
  );

  assign pump_en        = sleep_n;
  assign fault_pull_low = st.overcur;
  assign drv_en         = sleep_n && !uv_flag && st.settled && !st.thermal && !st.overcur;
endmodule

// File: rtl/drv_fault_supervisor_chk.sv
module drv_fault_supervisor_chk #(
  parameter int N_BRIDGE = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sleep_n,
  input logic                uv_flag,
  input logic                ot_trip,
  input logic [N_BRIDGE-1:0] short_det,
  input logic                drv_en,
  input logic                pump_en,
  input logic                fault_pull_low
);
  p_uv_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> !drv_en);
  p_trip_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ot_trip |=> !drv_en);
  p_latch_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pull_low) |-> ($past(|short_det) && $past(|short_det, 2)));
  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pull_low && sleep_n) |=> fault_pull_low);
  p_latch_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pull_low |-> !drv_en);
  p_sleep_wipes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !fault_pull_low);
  p_pump_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pump_en == sleep_n);
  p_sleep_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !drv_en);
endmodule

bind drv_fault_supervisor drv_fault_supervisor_chk #(.N_BRIDGE(N_BRIDGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .uv_flag(uv_flag), .ot_trip(ot_trip),
  .short_det(short_det), .drv_en(drv_en), .pump_en(pump_en), .fault_pull_low(fault_pull_low)
);

// File: tb/drv_fault_supervisor_bench.sv
module drv_fault_supervisor_bench;
  localparam int NB = 4;
  localparam int SC = 8;

  logic clk = 0, rst_n = 0, sleep_n = 1, ot_trip = 0, ot_clear = 0, uv_flag = 0;
  logic [NB-1:0] short_det = '0;
  logic drv_en, pump_en, fault_pull_low;
  int n_run = 0, n_fail = 0;
  bit m_hot = 0, m_oc = 0;
  bit [NB-1:0] m_seen = '0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  drv_fault_supervisor #(.N_BRIDGE(NB), .SETTLE_CYCLES(SC)) u_drv_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ot_trip(ot_trip), .ot_clear(ot_clear),
    .uv_flag(uv_flag), .short_det(short_det), .drv_en(drv_en), .pump_en(pump_en),
    .fault_pull_low(fault_pull_low)
  );

  function automatic bit exp_en();
    return sleep_n && !uv_flag && (m_cnt == SC) && !m_hot && !m_oc;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_hot = 0; m_oc = 0; m_seen = '0; m_cnt = 0;
    end else begin
      if (ot_trip) m_hot = 1; else if (ot_clear) m_hot = 0;
      if (!sleep_n) begin m_oc = 0; m_seen = '0; end
      else begin
        if (|(m_seen & short_det)) m_oc = 1;
        m_seen = short_det;
      end
      if (!sleep_n || uv_flag) m_cnt = 0; else if (m_cnt != SC) m_cnt++;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    check("R9", drv_en, exp_en());
    check("R8", fault_pull_low, m_oc);
    check("R7", pump_en, sleep_n);
  endtask

  task automatic settle();
    sleep_n = 1; uv_flag = 0; ot_trip = 0; ot_clear = 1; short_det = '0;
    repeat (SC + 2) step();
    ot_clear = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    // R1: reset state
    repeat (3) step();
    check("R1", drv_en, 1'b0);
    check("R1", fault_pull_low, 1'b0);
    rst_n = 1;
    step();
    check("R1", drv_en, 1'b0);
    // R2: settle count after power-up
    repeat (SC - 2) step();
    check("R2", drv_en, 1'b0);
    step();
    check("R2", drv_en, 1'b1);
    uv_flag = 1; #1;
    check("R2", drv_en, 1'b0);
    step(); uv_flag = 0;
    repeat (SC - 1) step();
    check("R2", drv_en, 1'b0);
    step();
    check("R2", drv_en, 1'b1);
    // R3: trip wins over clear, then release
    ot_trip = 1; ot_clear = 1; step();
    check("R3", drv_en, 1'b0);
    ot_trip = 0; ot_clear = 0; step();
    check("R3", drv_en, 1'b0);
    check("R8", fault_pull_low, 1'b0);
    ot_clear = 1; step(); ot_clear = 0;
    check("R3", drv_en, 1'b1);
    // R4: one-edge glitch ignored
    short_det = 4'b0010; step();
    short_det = 4'b0000; step();
    short_det = 4'b0100; step();
    short_det = 4'b0000; step();
    check("R4", fault_pull_low, 1'b0);
    check("R4", drv_en, 1'b1);
    // R4/R5: two edges latch, hold after release
    short_det = 4'b1000; step(); step();
    check("R4", fault_pull_low, 1'b1);
    short_det = '0; repeat (5) step();
    check("R5", fault_pull_low, 1'b1);
    check("R5", drv_en, 1'b0);
    // R6: sleep clears even with short still present
    short_det = 4'b0001; sleep_n = 0; step();
    check("R6", fault_pull_low, 1'b0);
    check("R7", pump_en, 1'b0);
    step();
    check("R6", fault_pull_low, 1'b0);
    sleep_n = 1; step();
    check("R6", fault_pull_low, 1'b0);
    short_det = '0;
    settle();
    check("R6", drv_en, 1'b1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 2) sleep_n = ~sleep_n;
      if (!sleep_n && $urandom_range(99) < 20) sleep_n = 1;
      uv_flag  = ($urandom_range(99) < 3);
      ot_trip  = ($urandom_range(99) < 2);
      ot_clear = ($urandom_range(99) < 15);
      for (int b = 0; b < NB; b++)
        if (short_det[b]) short_det[b] = ($urandom_range(99) < 50);
        else              short_det[b] = ($urandom_range(999) < 8);
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule